// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of a full-duplex SPI master. It takes words from a transmit FIFO through a valid/pop handshake, shifts them out on MOSI most significant bit first, and at the same time collects the same number of bits from MISO. Each finished word is handed to a receive FIFO with a one-cycle push strobe. A word can be 8, 16 or 32 bits long.

The serial clock comes from a 9-bit divisor: every half period of SCK lasts `cfg_div + 1` system clocks, so SCK runs at clk / (2 × (cfg_div + 1)). The idle level of SCK, the edge on which MOSI changes and the point at which MISO is captured are set independently. Each bit time has two halves of equal length. MOSI changes only at the start of a bit. The engine can also drive an active-low slave select by itself: the select is held while a word is shifting or another is waiting in the transmit FIFO, and is released when the FIFO has drained.

The engine shifts only while both `cfg_enable` and `cfg_master` are set. Configuration is expected to stay constant while `busy` is high.

Top module: `spi_shift_master`

## Requirements
- R1: Each half of a bit time lasts exactly `cfg_div + 1` clock cycles (including `cfg_div` = 0 and 511). A word of N bits keeps `busy` high for exactly 2 × (cfg_div + 1) × N cycles, and SCK changes level only where one half ends and the next begins.
- R2: While `busy` is low, SCK rests at the level of `cfg_cpol`: 0 when the bit is clear, 1 when it is set.
- R3: With `cfg_edge` = 1, SCK is at its idle level in the first half of every bit and at its active level in the second half, so MOSI changes on the active-to-idle edge. With `cfg_edge` = 0, SCK is active in the first half and idle in the second, so MOSI changes on the idle-to-active edge.
- R4: With `cfg_sample` = 0, MISO is captured at the clock edge that ends the first half of each bit. With `cfg_sample` = 1, it is captured at the edge that ends the second half.
- R5: `cfg_width` selects the word length: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits.
- R6: MOSI carries the low N bits of the popped word, most significant of those first, and holds each bit for a whole bit time. Bits of `tx_data` above N have no effect. `rx_data` holds the N received bits in its low bits, first-received bit highest, with zeros above.
- R7: With `cfg_auto_ss` = 1 and the engine enabled, `ss_n` is low whenever `busy` or `tx_valid` is high, and it returns high once both are low. With `cfg_auto_ss` = 0, or with the engine disabled, `ss_n` stays high.
- R8: Unless `cfg_enable` and `cfg_master` are both 1, no word is popped, `busy` stays low and SCK stays at its idle level, even when `tx_valid` is high.
- R9: `tx_pop` is asserted only while `tx_valid` is high. It pops the word on `tx_data` in that cycle. When a word is waiting as the current word finishes, it is popped in the current word's last cycle, and its first bit starts in the next cycle with no idle cycle in between.
- R10: `rx_push` is high for exactly one cycle, the cycle after the edge that ends the last bit of a word. `rx_data` is valid in that cycle. If no further word was popped, `busy` is low in that same cycle.
- R11: After reset, `busy`, `rx_push` and `tx_pop` are low, `ss_n` is high and SCK is at the `cfg_cpol` level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_master | input | 1 | Master mode select; must be 1 for the engine to shift |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_edge | input | 1 | 1: MOSI changes on the active-to-idle edge; 0: on the idle-to-active edge |
| cfg_sample | input | 1 | 0: capture MISO mid-bit; 1: capture at the end of the bit |
| cfg_width | input | 2 | Word length code (0: 8, 1: 16, 2/3: 32 bits) |
| cfg_auto_ss | input | 1 | Drive slave select from the transmit FIFO state |
| cfg_div | input | 9 | Half-period divisor; each half lasts cfg_div+1 clocks |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_data | input | 32 | Word at the head of the transmit FIFO |
| tx_pop | output | 1 | Takes the head word from the transmit FIFO this cycle |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| rx_push | output | 1 | One-cycle strobe that writes rx_data into the receive FIFO |
| rx_data | output | 32 | Received word, right-aligned |
| busy | output | 1 | A word is being shifted |

## Verification
Two events can land in the same cycle. One is the receive push of a finished word. The other is the pop of the next transmit word, together with the start of its first bit. The bench provokes this by keeping `tx_valid` high across three back-to-back words. Its slave model then requires three things: `tx_pop` appears in the last cycle of the current word, `rx_push` with the correct word appears in the first cycle of the next word, and the SCK and MOSI pattern of that next word begins with no idle cycle. In the non-chained case, the same push cycle is judged on `busy` having already cleared and on `ss_n` having been released.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  localparam int WORD_MAX = 32;
  localparam int BITS_W   = $clog2(WORD_MAX);

  typedef enum logic [1:0] {
    WCODE_8   = 2'd0,
    WCODE_16  = 2'd1,
    WCODE_32  = 2'd2,
    WCODE_32X = 2'd3
  } wcode_e;

  // number of bits in a word for a width code
  function automatic logic [BITS_W:0] code_bits(input logic [1:0] code);
    case (wcode_e'(code))
      WCODE_8:  code_bits = (BITS_W+1)'(8);
      WCODE_16: code_bits = (BITS_W+1)'(16);
      default:  code_bits = (BITS_W+1)'(WORD_MAX);
    endcase
  endfunction

  // keep only the low bits belonging to the word
  function automatic logic [WORD_MAX-1:0] low_bits(input logic [WORD_MAX-1:0] w,
                                                   input logic [1:0] code);
    logic [WORD_MAX-1:0] m;
    m = {WORD_MAX{1'b1}} >> (WORD_MAX - int'(code_bits(code)));
    low_bits = w & m;
  endfunction

  // move the word's top bit into the register's top bit
  function automatic logic [WORD_MAX-1:0] top_align(input logic [WORD_MAX-1:0] w,
                                                    input logic [1:0] code);
    top_align = w << (WORD_MAX - int'(code_bits(code)));
  endfunction

endpackage

// File: rtl/spi_baud_timer.sv
module spi_baud_timer #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DIV_W-1:0] div,
  output logic             phase_end,
  output logic             half
);

  logic [DIV_W-1:0] cnt;

  assign phase_end = active && (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (!active) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (phase_end) begin
      cnt  <= '0;
      half <= ~half;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path
  import spi_shift_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WORD_MAX-1:0] load_word,
  input  logic [1:0]          load_code,
  input  logic                advance,
  input  logic                capture,
  input  logic                miso,
  output logic                out_bit,
  output logic [WORD_MAX-1:0] rx_word,
  output logic [WORD_MAX-1:0] rx_next
);

  logic [WORD_MAX-1:0] tx_sh;

  assign out_bit = tx_sh[WORD_MAX-1];
  assign rx_next = {rx_word[WORD_MAX-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
    end else if (load) begin
      tx_sh <= top_align(load_word, load_code);
    end else if (advance) begin
      tx_sh <= tx_sh << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word <= '0;
    end else if (load) begin
      rx_word <= '0;
    end else if (capture) begin
      rx_word <= rx_next;
    end
  end

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_shift_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic                cfg_master,
  input  logic                cfg_cpol,
  input  logic                cfg_edge,
  input  logic                cfg_sample,
  input  logic [1:0]          cfg_width,
  input  logic                cfg_auto_ss,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                tx_valid,
  input  logic [WORD_MAX-1:0] tx_data,
  output logic                tx_pop,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output logic                ss_n,
  output logic                rx_push,
  output logic [WORD_MAX-1:0] rx_data,
  output logic                busy
);

  // named internal events
  logic                run;
  logic                phase_end;
  logic                half;
  logic                bit_end;
  logic                word_end;
  logic                capture;
  logic                advance;
  logic                out_bit;
  logic [BITS_W-1:0]   bits_left;
  logic [1:0]          code_q;
  logic [WORD_MAX-1:0] rx_word;
  logic [WORD_MAX-1:0] rx_next;
  logic [WORD_MAX-1:0] rx_final;

  assign run      = cfg_enable & cfg_master;
  assign bit_end  = phase_end & half;
  assign word_end = bit_end & (bits_left == '0);
  assign capture  = phase_end & (half == cfg_sample);
  assign advance  = bit_end & ~word_end;
  assign tx_pop   = run & tx_valid & (~busy | word_end);
  assign rx_final = cfg_sample ? rx_next : rx_word;

  spi_baud_timer #(.DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (busy),
    .div       (cfg_div),
    .phase_end (phase_end),
    .half      (half)
  );

  spi_shift_path u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_pop),
    .load_word (tx_data),
    .load_code (cfg_width),
    .advance   (advance),
    .capture   (capture),
    .miso      (miso),
    .out_bit   (out_bit),
    .rx_word   (rx_word),
    .rx_next   (rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bits_left <= '0;
      code_q    <= '0;
      rx_push   <= 1'b0;
      rx_data   <= '0;
    end else begin
      rx_push <= 1'b0;
      if (!run) begin
        busy <= 1'b0;
      end else begin
        if (word_end) begin
          rx_push <= 1'b1;
          rx_data <= low_bits(rx_final, code_q);
        end
        if (tx_pop) begin
          busy      <= 1'b1;
          bits_left <= BITS_W'(code_bits(cfg_width) - 1'b1);
          code_q    <= cfg_width;
        end else if (word_end) begin
          busy <= 1'b0;
        end else if (advance) begin
          bits_left <= bits_left - 1'b1;
        end
      end
    end
  end

  // active level in first half when edge bit clear, second half when set
  assign sck  = cfg_cpol ^ (busy & (half ^ ~cfg_edge));
  assign mosi = busy & out_bit;
  assign ss_n = ~(cfg_auto_ss & run & (busy | tx_valid));

endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_cpol,
  input logic cfg_edge,
  input logic cfg_auto_ss,
  input logic run,
  input logic tx_valid,
  input logic tx_pop,
  input logic busy,
  input logic sck,
  input logic mosi,
  input logic ss_n,
  input logic rx_push,
  input logic phase_end,
  input logic bit_end
);

  // R9
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);

  // R8
  gated_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tx_pop);

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cfg_cpol));

  // R7
  select_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_ss && run && busy) |-> !ss_n);

  // R1
  sck_on_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(cfg_cpol) && $stable(cfg_edge) && (sck != $past(sck)))
      |-> $past(phase_end));

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_end)) |-> $stable(mosi));

  // R10
  push_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(run)) |-> rx_push);

  // R10
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

endmodule

bind spi_shift_master spi_shift_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_cpol    (cfg_cpol),
  .cfg_edge    (cfg_edge),
  .cfg_auto_ss (cfg_auto_ss),
  .run         (run),
  .tx_valid    (tx_valid),
  .tx_pop      (tx_pop),
  .busy        (busy),
  .sck         (sck),
  .mosi        (mosi),
  .ss_n        (ss_n),
  .rx_push     (rx_push),
  .phase_end   (phase_end),
  .bit_end     (bit_end)
);

// File: tb/spi_shift_master_test.sv
`timescale 1ns/1ps
module spi_shift_master_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, cfg_master, cfg_cpol, cfg_edge, cfg_sample, cfg_auto_ss;
  logic [1:0]  cfg_width;
  logic [8:0]  cfg_div;
  logic        tx_valid;
  logic [31:0] tx_data;
  logic        tx_pop;
  logic        miso;
  logic        sck, mosi, ss_n, rx_push, busy;
  logic [31:0] rx_data;

  always #2.5 clk = ~clk;

  spi_shift_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
    .cfg_cpol(cfg_cpol), .cfg_edge(cfg_edge), .cfg_sample(cfg_sample),
    .cfg_width(cfg_width), .cfg_auto_ss(cfg_auto_ss), .cfg_div(cfg_div),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .miso(miso),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .rx_push(rx_push), .rx_data(rx_data),
    .busy(busy)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct packed { logic [31:0] t; logic [31:0] m; } item_t;
  item_t q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] c);
    return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] keep(input logic [31:0] w, input int n);
    return (n == 8) ? (w & 32'hFF) : (n == 16) ? (w & 32'hFFFF) : w;
  endfunction

  task automatic setcfg(input bit en, input bit ms, input bit cp, input bit ed, input bit sm,
                        input logic [1:0] wd, input bit au, input logic [8:0] dv);
    @(posedge clk); #1;
    cfg_enable = en; cfg_master = ms; cfg_cpol = cp; cfg_edge = ed;
    cfg_sample = sm; cfg_width = wd; cfg_auto_ss = au; cfg_div = dv;
  endtask

  // driver: queue the expected item and offer the word until popped
  task automatic send(input logic [31:0] t, input logic [31:0] m);
    q.push_back({t, m});
    tx_data  = t;
    tx_valid = 1'b1;
    do @(negedge clk); while (!tx_pop);
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || tx_valid || q.size() != 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic gate_test(input bit en, input bit ms);
    bit ok_pop, ok_ss;
    setcfg(en, ms, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 9'd0);
    tx_data = 32'h0000_0077; tx_valid = 1'b1;
    ok_pop = 1'b1; ok_ss = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (tx_pop !== 1'b0 || busy !== 1'b0 || sck !== 1'b0) ok_pop = 1'b0;
      if (ss_n !== 1'b1) ok_ss = 1'b0;
    end
    chk(ok_pop, "R8 no pop/shift while not enabled as master", {31'd0, ok_pop}, 32'd1);
    chk(ok_ss, "R7 select high while engine disabled", {31'd0, ok_ss}, 32'd1);
    @(posedge clk); #1 tx_valid = 1'b0;
  endtask

  // monitor: slave model and scoreboard
  item_t take_item;
  function automatic item_t take();
    item_t it;
    if (q.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL R9 pop with empty queue actual=%h expected=%h", tx_data, 32'h0);
      it = '0;
    end else begin
      it = q.pop_front();
      n_chk++;
      if (tx_data !== it.t) begin
        n_bad++;
        $display("FAIL R9 popped word actual=%h expected=%h", tx_data, it.t);
      end
    end
    return it;
  endfunction

  task automatic check_push(input logic [31:0] exp, input bit chained);
    chk(rx_push === 1'b1, "R10 push strobe", {31'd0, rx_push}, 32'd1);
    chk(rx_data === exp, "R4 R6 received word", rx_data, exp);
    if (!chained) begin
      chk(busy === 1'b0, "R10 busy clear with push", {31'd0, busy}, 32'd0);
      chk(ss_n === 1'b1, "R7 select released after drain", {31'd0, ss_n}, 32'd1);
    end
  endtask

  initial begin : slave
    bit go, push_due, nxt, chained;
    bit ok_sck, ok_mosi, ok_busy, ok_ss;
    logic [31:0] exp_rx;
    item_t cur, nc;
    int n, d;
    logic exp_sck, b;
    go = 0; push_due = 0; chained = 0; exp_rx = '0; cur = '0; nc = '0;
    miso = 1'b0;
    forever begin
      if (!go) begin
        @(negedge clk);
        if (push_due) begin check_push(exp_rx, 1'b0); push_due = 0; end
        if (tx_pop) begin go = 1; cur = take(); end
      end else begin
        n = nbits(cfg_width); d = int'(cfg_div) + 1;
        ok_sck = 1; ok_mosi = 1; ok_busy = 1; ok_ss = 1; nxt = 0;
        for (int k = 0; k < n; k++) begin
          for (int c = 0; c < 2 * d; c++) begin
            @(negedge clk);
            if (k == 0 && c == 0 && push_due) begin check_push(exp_rx, chained); push_due = 0; end
            b = cur.m[n-1-k];
            if (c == 0) miso = b;
            if (c == d) miso = ~b;
            exp_sck = cfg_cpol ^ ((c < d) ? ~cfg_edge : cfg_edge);
            if (sck !== exp_sck) ok_sck = 0;
            if (mosi !== cur.t[n-1-k]) ok_mosi = 0;
            if (busy !== 1'b1) ok_busy = 0;
            if (ss_n !== ~cfg_auto_ss) ok_ss = 0;
            if (k == n - 1 && c == 2 * d - 1 && tx_pop) begin nxt = 1; nc = take(); end
          end
        end
        chk(ok_sck, "R1 R3 SCK half-period pattern", {31'd0, ok_sck}, 32'd1);
        chk(ok_mosi, "R5 R6 MOSI bit order", {31'd0, ok_mosi}, 32'd1);
        chk(ok_busy, "R1 busy for whole word", {31'd0, ok_busy}, 32'd1);
        chk(ok_ss, "R7 select during word", {31'd0, ok_ss}, 32'd1);
        exp_rx = keep(cfg_sample ? ~cur.m : cur.m, n);
        push_due = 1; chained = nxt; go = nxt; cur = nc;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0;
    cfg_enable = 0; cfg_master = 0; cfg_cpol = 0; cfg_edge = 1; cfg_sample = 0;
    cfg_width = 2'd0; cfg_auto_ss = 1; cfg_div = 9'd0;
    tx_valid = 1'b0; tx_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busy === 1'b0, "R11 busy after reset", {31'd0, busy}, 32'd0);
    chk(rx_push === 1'b0, "R11 push after reset", {31'd0, rx_push}, 32'd0);
    chk(tx_pop === 1'b0, "R11 pop after reset", {31'd0, tx_pop}, 32'd0);
    chk(ss_n === 1'b1, "R11 select after reset", {31'd0, ss_n}, 32'd1);
    chk(sck === 1'b0, "R11 R2 SCK idle low", {31'd0, sck}, 32'd0);

    // R2 idle high with polarity set
    setcfg(1, 1, 1, 1, 0, 2'd0, 1, 9'd0);
    @(negedge clk);
    chk(sck === 1'b1, "R2 SCK idle high", {31'd0, sck}, 32'd1);

    // 8-bit, upper tx bits must be ignored (R6), mid-bit sample (R4)
    setcfg(1, 1, 0, 1, 0, 2'd0, 1, 9'd0);
    send(32'hDEAD_BEA5, 32'h0000_003C);
    wait_idle();

    // 16-bit, polarity high, edge clear, end sample, divisor 2
    setcfg(1, 1, 1, 0, 1, 2'd1, 1, 9'd2);
    send(32'h0000_C3E1, 32'h0000_5A0F);
    wait_idle();

    // 32-bit code 2, end sample, divisor 1
    setcfg(1, 1, 0, 1, 1, 2'd2, 1, 9'd1);
    send(32'h8123_4567, 32'hF00D_BEEF);
    wait_idle();

    // 32-bit via code 3, automatic select off
    setcfg(1, 1, 1, 1, 0, 2'd3, 0, 9'd0);
    send(32'h1357_9BDF, 32'h2468_ACE0);
    wait_idle();

    // R9 back-to-back words: push and next pop share the boundary
    setcfg(1, 1, 0, 0, 0, 2'd0, 1, 9'd1);
    send(32'h0000_0096, 32'h0000_00C1);
    send(32'h0000_0013, 32'h0000_00FE);
    send(32'h0000_00E8, 32'h0000_0055);
    wait_idle();

    // R1 largest divisor
    setcfg(1, 1, 0, 1, 1, 2'd0, 1, 9'd511);
    send(32'h0000_0081, 32'h0000_0042);
    wait_idle();

    // R8 gating by enable and by master mode
    gate_test(1'b0, 1'b1);
    gate_test(1'b1, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule